// File: doc/BRIEF.md
# Write-Triggered Descriptor Enqueue Front End

This block is the register front end of a job queue. Software programs the fields of a job descriptor through a small 32-bit register window with byte addresses and word-aligned accesses. Three registers hold the descriptor fields: a base address for the configuration and filter data, a configuration length, and a base address for the input and output data. Writing the input/output base register commits the job. On that write, the current values of all three fields are pushed together into an internal FIFO. The configuration fields are not cleared by a push, so a run of jobs that share one configuration needs only one write each.

A downstream engine drains the FIFO through a valid/ready pop port and receives all three fields in parallel. A read-only status register reports three things: a sticky overflow flag, a flag for a queue at or above its almost-full level, and a flag for a queue so full that the next push will be rejected. A push with a base address that is not a multiple of the memory word size is rejected and raises a one-cycle error pulse.

Top module: `desc_enqueue_top`

## Requirements
- R1: After reset, every register reads 0, the status register reads 0, `descValid` is 0 and `alignErr` is 0.
- R2: A write to byte offset 0x0 (configuration base) or 0x4 (configuration length, in 64-bit configuration words minus 2, stored as written) updates that register's readback value. It does not push a descriptor.
- R3: A write to offset 0x8 stores the input/output base. When both bases are aligned and the queue is not full, that write pushes {configuration base, length, written input/output base}. `descValid` is high in the cycle after the write.
- R4: The configuration base and length keep their values across pushes. Successive writes to 0x8 enqueue descriptors that share those values, and the descriptors leave the queue in push order.
- R5: A descriptor is popped on a clock edge where `descValid` and `descReady` are both high. While `descReady` is low, the head descriptor and `descValid` stay unchanged.
- R6: Status bit 1 (offset 0xC) is 1 exactly when the number of queued descriptors is at least `AF_LEVEL` (default `DEPTH`-1).
- R7: Status bit 2 is 1 exactly when the queue holds `DEPTH` descriptors. A write to 0x8 in that state pushes nothing, and the queue contents are unchanged. This holds even when a pop happens in the same cycle.
- R8: Status bit 0 is set by a write to 0x8 while the queue is full. It stays set through later pops and pushes, and only reset clears it.
- R9: A write to 0x8 is rejected without a push when the configuration base or the written input/output base has any of its low log2(`WORD_BYTES`) bits set. In that case `alignErr` is high for exactly the one cycle after the write.
- R10: Writes to offset 0xC have no effect on the status value or on the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Register write strobe |
| csrAddr | input | CSR_ADDR_W | Byte address of the access |
| csrWrData | input | 32 | Write data |
| csrRdData | output | 32 | Read data for `csrAddr` (combinational) |
| descReady | input | 1 | Consumer accepts the head descriptor |
| descValid | output | 1 | Queue holds at least one descriptor |
| descCfgBase | output | 32 | Head descriptor configuration/filter base |
| descCfgLen | output | 32 | Head descriptor configuration length |
| descIoBase | output | 32 | Head descriptor input/output base |
| alignErr | output | 1 | One-cycle pulse after a rejected misaligned push |

## Verification
The assertions take for granted that `csrAddr` uses only word-aligned offsets, and that `descReady` is only raised while `descValid` is high. The bench keeps to both: it drives only the four offsets 0x0, 0x4, 0x8 and 0xC, and it raises `descReady` only after it has seen `descValid` high. The bench fills the queue through every occupancy level from empty to full and checks both flag bits at each level. It then overruns the queue and drains it completely against a model queue kept in the bench. Pushes that are misaligned on each base are mixed in with the legal ones.

// File: rtl/desc_enqueue_pkg.sv
package desc_enqueue_pkg;

  typedef enum logic [1:0] {
    SEL_CFG_BASE = 2'd0,
    SEL_CFG_LEN  = 2'd1,
    SEL_IO_BASE  = 2'd2,
    SEL_STATUS   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic loadCfgBase;
    logic loadCfgLen;
    logic loadIoBase;
    logic push;
    logic setOverflow;
    logic alignReject;
  } ctrlStrobes_t;

endpackage

// File: rtl/desc_enqueue_ctrl.sv
module desc_enqueue_ctrl
  import desc_enqueue_pkg::*;
#(
  parameter int CSR_ADDR_W = 4,
  parameter int WORD_BYTES = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csrWrEn,
  input  logic [CSR_ADDR_W-1:0] csrAddr,
  input  logic [31:0]           csrWrData,
  input  logic [31:0]           heldCfgBase,
  input  logic                  queueFull,
  output ctrlStrobes_t          strb,
  output logic                  alignErr
);

  localparam int LSB_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;

  regSel_e sel;
  logic    inWindow;
  logic    basesAligned;

  assign sel      = regSel_e'(csrAddr[3:2]);
  assign inWindow = ((csrAddr >> 4) == '0);

  generate
    if (LSB_W == 0) begin : g_noAlign
      assign basesAligned = 1'b1;
    end else begin : g_align
      assign basesAligned = (heldCfgBase[LSB_W-1:0] == '0) &&
                            (csrWrData[LSB_W-1:0] == '0);
    end
  endgenerate

  always_comb begin
    strb = '0;
    if (csrWrEn && inWindow) begin
      unique case (sel)
        SEL_CFG_BASE: strb.loadCfgBase = 1'b1;
        SEL_CFG_LEN:  strb.loadCfgLen  = 1'b1;
        SEL_IO_BASE: begin
          strb.loadIoBase  = 1'b1;
          strb.setOverflow = queueFull;
          strb.alignReject = !basesAligned;
          strb.push        = basesAligned && !queueFull;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) alignErr <= 1'b0;
    else       alignErr <= strb.alignReject;
  end

  // R2: writes to other offsets never push
  a_r2_push_only_from_io: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && sel != SEL_IO_BASE) |-> !strb.push)
    else $error("a_r2_push_only_from_io");

  // R9: a rejected write produces a pulse and no push
  a_r9_reject_no_push: assert property (@(posedge clk) disable iff (!rstN)
    strb.alignReject |-> (!strb.push ##1 alignErr))
    else $error("a_r9_reject_no_push");

  // R7: no push enters a full queue
  a_r7_full_no_push: assert property (@(posedge clk) disable iff (!rstN)
    queueFull |-> !strb.push)
    else $error("a_r7_full_no_push");

endmodule

// File: rtl/desc_enqueue_data.sv
module desc_enqueue_data
  import desc_enqueue_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int AF_LEVEL = DEPTH - 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  input  logic [31:0]  wrData,
  input  logic [1:0]   rdSel,
  input  logic         rdInWindow,
  input  logic         descReady,
  output logic [31:0]  rdData,
  output logic [31:0]  heldCfgBase,
  output logic         queueFull,
  output logic         descValid,
  output logic [31:0]  descCfgBase,
  output logic [31:0]  descCfgLen,
  output logic [31:0]  descIoBase
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] AF_CNT   = CNT_W'(AF_LEVEL);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [31:0] cfgBaseQ, cfgLenQ, ioBaseQ;
  logic [31:0] memCfgBase [DEPTH];
  logic [31:0] memCfgLen  [DEPTH];
  logic [31:0] memIoBase  [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic overflowQ, almostFull, pop;

  assign queueFull   = (count == FULL_CNT);
  assign almostFull  = (count >= AF_CNT);
  assign descValid   = (count != '0);
  assign pop         = descValid && descReady;
  assign heldCfgBase = cfgBaseQ;
  assign descCfgBase = memCfgBase[rdPtr];
  assign descCfgLen  = memCfgLen[rdPtr];
  assign descIoBase  = memIoBase[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBaseQ  <= '0;
      cfgLenQ   <= '0;
      ioBaseQ   <= '0;
      overflowQ <= 1'b0;
    end else begin
      if (strb.loadCfgBase) cfgBaseQ <= wrData;
      if (strb.loadCfgLen)  cfgLenQ  <= wrData;
      if (strb.loadIoBase)  ioBaseQ  <= wrData;
      if (strb.setOverflow) overflowQ <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          memCfgBase[i] <= '0;
          memCfgLen[i]  <= '0;
          memIoBase[i]  <= '0;
        end else if (strb.push && wrPtr == PTR_W'(i)) begin
          memCfgBase[i] <= cfgBaseQ;
          memCfgLen[i]  <= cfgLenQ;
          memIoBase[i]  <= wrData;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)       rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(strb.push) - CNT_W'(pop);
    end
  end

  always_comb begin
    rdData = '0;
    if (rdInWindow) begin
      unique case (regSel_e'(rdSel))
        SEL_CFG_BASE: rdData = cfgBaseQ;
        SEL_CFG_LEN:  rdData = cfgLenQ;
        SEL_IO_BASE:  rdData = ioBaseQ;
        SEL_STATUS:   rdData = {29'd0, queueFull, almostFull, overflowQ};
        default:      rdData = '0;
      endcase
    end
  end

  // R8: overflow flag is sticky until reset
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflowQ |=> overflowQ)
    else $error("a_r8_overflow_sticky");

  // R5: head is held while the consumer stalls
  a_r5_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && !descReady) |=> (descValid && $stable(descCfgBase) &&
                                   $stable(descCfgLen) && $stable(descIoBase)))
    else $error("a_r5_head_hold");

  // R7: occupancy never exceeds the depth
  a_r7_bounded: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT)
    else $error("a_r7_bounded");

  // R7: a full queue without a pop stays full
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (queueFull && !pop) |=> queueFull)
    else $error("a_r7_full_holds");

endmodule

// File: rtl/desc_enqueue_top.sv
module desc_enqueue_top
  import desc_enqueue_pkg::*;
#(
  parameter int CSR_ADDR_W = 4,
  parameter int DEPTH      = 8,
  parameter int AF_LEVEL   = DEPTH - 1,
  parameter int WORD_BYTES = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csrWrEn,
  input  logic [CSR_ADDR_W-1:0] csrAddr,
  input  logic [31:0]           csrWrData,
  output logic [31:0]           csrRdData,
  input  logic                  descReady,
  output logic                  descValid,
  output logic [31:0]           descCfgBase,
  output logic [31:0]           descCfgLen,
  output logic [31:0]           descIoBase,
  output logic                  alignErr
);

  ctrlStrobes_t strb;
  logic [31:0]  heldCfgBase;
  logic         queueFull;

  desc_enqueue_ctrl #(
    .CSR_ADDR_W (CSR_ADDR_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .csrWrEn     (csrWrEn),
    .csrAddr     (csrAddr),
    .csrWrData   (csrWrData),
    .heldCfgBase (heldCfgBase),
    .queueFull   (queueFull),
    .strb        (strb),
    .alignErr    (alignErr)
  );

  desc_enqueue_data #(
    .DEPTH    (DEPTH),
    .AF_LEVEL (AF_LEVEL)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (csrWrData),
    .rdSel       (csrAddr[3:2]),
    .rdInWindow  ((csrAddr >> 4) == '0),
    .descReady   (descReady),
    .rdData      (csrRdData),
    .heldCfgBase (heldCfgBase),
    .queueFull   (queueFull),
    .descValid   (descValid),
    .descCfgBase (descCfgBase),
    .descCfgLen  (descCfgLen),
    .descIoBase  (descIoBase)
  );

endmodule

// File: tb/desc_enqueue_top_tb.sv
module desc_enqueue_top_tb;

  localparam int DEPTH = 8;
  localparam int AF    = DEPTH - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [3:0]  csrAddr = '0;
  logic [31:0] csrWrData = '0;
  logic [31:0] csrRdData;
  logic        descReady = 1'b0;
  logic        descValid;
  logic [31:0] descCfgBase, descCfgLen, descIoBase;
  logic        alignErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [31:0] qCfg[$];
  logic [31:0] qLen[$];
  logic [31:0] qIo[$];
  logic [31:0] curCfg = '0, curLen = '0;

  always #5 clk = ~clk;

  desc_enqueue_top u_dut (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrAddr(csrAddr),
    .csrWrData(csrWrData), .csrRdData(csrRdData), .descReady(descReady),
    .descValid(descValid), .descCfgBase(descCfgBase), .descCfgLen(descCfgLen),
    .descIoBase(descIoBase), .alignErr(alignErr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] addr, logic [31:0] data);
    @(negedge clk);
    csrWrEn = 1'b1; csrAddr = addr; csrWrData = data;
    @(negedge clk);
    csrWrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] addr, output logic [31:0] data);
    csrAddr = addr;
    #1;
    data = csrRdData;
  endtask

  // push with model update; legal only when aligned and not full
  task automatic pushIo(logic [31:0] io);
    bit ok;
    ok = (curCfg[5:0] == 0) && (io[5:0] == 0) && (qIo.size() < DEPTH);
    wr(4'h8, io);
    if (ok) begin
      qCfg.push_back(curCfg); qLen.push_back(curLen); qIo.push_back(io);
    end
  endtask

  task automatic popCheck(string req);
    check(req, {31'd0, descValid}, 32'd1);
    check(req, descCfgBase, qCfg[0]);
    check(req, descCfgLen,  qLen[0]);
    check(req, descIoBase,  qIo[0]);
    void'(qCfg.pop_front()); void'(qLen.pop_front()); void'(qIo.pop_front());
    descReady = 1'b1;
    @(negedge clk);
    descReady = 1'b0;
  endtask

  task automatic status(string req, logic ovf);
    logic [31:0] v;
    int n;
    n = qIo.size();
    rd(4'hC, v);
    check(req, v, {29'd0, (n == DEPTH), (n >= AF), ovf});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), v);
      check("R1", v, 32'd0);
    end
    check("R1", {31'd0, descValid}, 32'd0);
    check("R1", {31'd0, alignErr}, 32'd0);

    // R2 configuration writes do not push
    curCfg = 32'h0000_1000; wr(4'h0, curCfg);
    curLen = 32'd5;         wr(4'h4, curLen);
    rd(4'h0, v); check("R2", v, curCfg);
    rd(4'h4, v); check("R2", v, curLen);
    check("R2", {31'd0, descValid}, 32'd0);

    // R3 push on io write
    pushIo(32'h0000_2000);
    check("R3", {31'd0, descValid}, 32'd1);
    rd(4'h8, v); check("R3", v, 32'h0000_2000);
    check("R3", descIoBase, 32'h0000_2000);

    // R4 held fields reused, then changed
    pushIo(32'h0000_2040);
    pushIo(32'h0000_2080);
    curCfg = 32'h0000_3000; wr(4'h0, curCfg);
    curLen = 32'd7;         wr(4'h4, curLen);
    pushIo(32'h0000_0040);

    // R5 stall keeps head stable
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R5", descIoBase, qIo[0]);
    end
    while (qIo.size() > 0) popCheck("R4");
    check("R5", {31'd0, descValid}, 32'd0);

    // R6 R7 sweep occupancy 0..DEPTH
    status("R6", 1'b0);
    for (int n = 1; n <= DEPTH; n++) begin
      pushIo(32'h0001_0000 + 32'(n) * 32'h40);
      status("R6", 1'b0);
      status("R7", 1'b0);
    end

    // R10 write to status ignored
    wr(4'hC, 32'hFFFF_FFFF);
    status("R10", 1'b0);

    // R7 R8 overflow: push while full, also with simultaneous pop
    pushIo(32'h0009_0000);
    status("R8", 1'b1);
    @(negedge clk);
    csrWrEn = 1'b1; csrAddr = 4'h8; csrWrData = 32'h000A_0000; descReady = 1'b1;
    check("R7", descIoBase, qIo[0]);
    void'(qCfg.pop_front()); void'(qLen.pop_front()); void'(qIo.pop_front());
    @(negedge clk);
    csrWrEn = 1'b0; descReady = 1'b0;
    status("R7", 1'b1);
    while (qIo.size() > 0) popCheck("R7");
    check("R7", {31'd0, descValid}, 32'd0);
    status("R8", 1'b1);
    pushIo(32'h0000_0080);
    popCheck("R8");
    status("R8", 1'b1);

    // R9 misaligned io base
    pushIo(32'h0000_2001);
    check("R9", {31'd0, alignErr}, 32'd1);
    check("R9", {31'd0, descValid}, 32'd0);
    @(negedge clk);
    check("R9", {31'd0, alignErr}, 32'd0);
    // R9 misaligned cfg base, sweep low bits
    for (int b = 0; b < 6; b++) begin
      curCfg = 32'h0000_4000 | (32'd1 << b); wr(4'h0, curCfg);
      pushIo(32'h0000_5000);
      check("R9", {31'd0, alignErr}, 32'd1);
      check("R9", {31'd0, descValid}, 32'd0);
    end
    curCfg = 32'h0000_4000; wr(4'h0, curCfg);
    check("R9", {31'd0, alignErr}, 32'd0);
    pushIo(32'h0000_5000);
    check("R9", {31'd0, alignErr}, 32'd0);
    popCheck("R9");

    // R8 reset clears overflow; R1 after reset
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    qCfg.delete(); qLen.delete(); qIo.delete();
    status("R8", 1'b0);
    rd(4'h0, v); check("R1", v, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule